// File: doc/BRIEF.md
# Lock-Step SIMD Processing Element Array

This block is a small single-instruction, multiple-data engine. One sequencer holds a program in its own instruction store. It fetches one instruction and decodes it, then broadcasts the decoded operation to four processing elements in the same cycle. Each processing element has an 8-bit accumulator, an ALU and a private 16-word data store. Every processing element applies the broadcast operation to its own accumulator, and takes its operand from its own data store at the address that came with the broadcast.

A per-element enable mask decides which elements take part in each operation. An element whose mask bit is clear keeps its accumulator and its data store unchanged. A ring network moves data between elements on command from the sequencer.

The host works through three paths:
- A valid/ready write port loads the instruction store and the data stores.
- A plain start pin launches a run.
- A plain read port gives access to any data-store word, so results are visible after a run.

The write port applies back-pressure for the whole run. `host_ready` is low while the engine is busy. A word is taken only on a cycle where `host_valid` and `host_ready` are both high. The host holds its word until that happens.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, `busy` and `done` are low, `host_ready` is high, and every data-store word reads as zero.
- R2: A host word is written only on a cycle where `host_valid` and `host_ready` are both high. `host_ready` is low while `busy` is high, and a word offered during a run leaves every store unchanged. `host_to_prog` high selects the instruction store; low selects the data store of element `host_pe`.
- R3: An instruction is 8 bits wide. The opcode is in bits [7:5] and the operand is in bits [4:0]. The opcodes are LOAD=0, STORE=1, ADD=2, SUB=3, AND=4, SETMASK=5, ROUTE=6 and HALT=7. For memory operations, each enabled element uses operand bits [3:0] as an address into its own data store.
- R4: In enabled elements, LOAD copies the addressed word into the accumulator. ADD and SUB add or subtract the word modulo 256. AND takes the bitwise AND of the accumulator and the word.
- R5: STORE writes the accumulator of each enabled element into that element's own data store at the operand address.
- R6: SETMASK loads operand bits [3:0] into the mask, where bit i enables element i. The mask is all ones when a run starts. A disabled element keeps both its accumulator and its data store.
- R7: ROUTE gives each enabled element i the accumulator value that element (i-1) mod 4 held before the instruction. The source value is taken whether or not the source element is enabled.
- R8: Every instruction takes two cycles, one to fetch and one to execute. If start is sampled at clock edge E, a program of N instructions that ends with HALT raises `done` at edge E+2N.
- R9: A start sampled while idle clears `done` and all accumulators, fills the mask with ones and begins at instruction address 0. A start sampled while busy has no effect.
- R10: HALT sets `done` and returns the engine to idle. `done` stays high until the next accepted start.
- R11: `rd_data` shows, without a clock delay, the word at `rd_addr` in the data store of element `rd_pe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host offers a store word |
| host_ready | output | 1 | Store word can be accepted (idle) |
| host_to_prog | input | 1 | 1: instruction store, 0: data store |
| host_pe | input | 2 | Target element for data-store writes |
| host_addr | input | 5 | Word address (low 4 bits for data stores) |
| host_data | input | 8 | Word to write |
| start | input | 1 | Launch a run from address 0 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run ended on HALT |
| rd_pe | input | 2 | Element selected for readout |
| rd_addr | input | 4 | Data-store address for readout |
| rd_data | output | 8 | Word read out |

## Verification
The assertions rely on the host staying off the stores while the engine runs. They also rely on the program always ending with HALT, so that the idle state is reached again. The bench offers words only through the handshake and ends every program with HALT. It sends a write and a start pulse during a run only on purpose, to show that both are ignored. All inputs change on the falling clock edge, so the sequencer never sees a change in the middle of a cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int OPW  = 3;
  localparam int OPRW = 5;
  localparam int IW   = OPW + OPRW;

  typedef enum logic [OPW-1:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_ADD     = 3'd2,
    OP_SUB     = 3'd3,
    OP_AND     = 3'd4,
    OP_SETMASK = 3'd5,
    OP_ROUTE   = 3'd6,
    OP_HALT    = 3'd7
  } op_e;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int NPE    = 4,
  parameter int PDEPTH = 32,
  localparam int PAW   = $clog2(PDEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            prog_we,
  input  logic [PAW-1:0]  prog_waddr,
  input  logic [IW-1:0]   prog_wdata,
  output logic            busy,
  output logic            done,
  output logic            op_valid,
  output op_e             op,
  output logic [OPRW-1:0] operand,
  output logic [NPE-1:0]  mask,
  output logic            clr_acc
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} state_e;

  state_e          state;
  logic [PAW-1:0]  pc;
  logic [IW-1:0]   ir;
  logic [IW-1:0]   prog [PDEPTH];

  always_ff @(posedge clk) begin
    if (prog_we) prog[prog_waddr] <= prog_wdata;
  end

  assign op       = op_e'(ir[IW-1 -: OPW]);
  assign operand  = ir[OPRW-1:0];
  assign op_valid = (state == S_EXEC);
  assign busy     = (state != S_IDLE);
  assign clr_acc  = (state == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
      ir    <= '0;
      done  <= 1'b0;
      mask  <= '1;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_FETCH;
            pc    <= '0;
            done  <= 1'b0;
            mask  <= '1;
          end
        end
        S_FETCH: begin
          ir    <= prog[pc];
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (op == OP_HALT) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            if (op == OP_SETMASK) mask <= operand[NPE-1:0];
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LDEPTH = 16,
  localparam int LAW   = $clog2(LDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           op_valid,
  input  logic           en,
  input  op_e            op,
  input  logic [LAW-1:0] addr,
  input  logic [DW-1:0]  route_in,
  input  logic           host_we,
  input  logic [LAW-1:0] host_waddr,
  input  logic [DW-1:0]  host_wdata,
  input  logic [LAW-1:0] host_raddr,
  output logic [DW-1:0]  acc,
  output logic [DW-1:0]  host_rdata
);
  logic [DW-1:0] mem [LDEPTH];
  logic [DW-1:0] opnd;
  logic          act;

  assign opnd       = mem[addr];
  assign host_rdata = mem[host_raddr];
  assign act        = op_valid && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LDEPTH; k++) mem[k] <= '0;
    end else if (host_we) begin
      mem[host_waddr] <= host_wdata;
    end else if (act && op == OP_STORE) begin
      mem[addr] <= acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc <= '0;
    end else if (act) begin
      case (op)
        OP_LOAD:  acc <= opnd;
        OP_ADD:   acc <= acc + opnd;
        OP_SUB:   acc <= acc - opnd;
        OP_AND:   acc <= acc & opnd;
        OP_ROUTE: acc <= route_in;
        default:  acc <= acc;
      endcase
    end
  end
endmodule

// File: rtl/simd_ring_net.sv
module simd_ring_net #(
  parameter int NPE = 4,
  parameter int DW  = 8
) (
  input  logic [NPE*DW-1:0] acc_flat,
  output logic [NPE*DW-1:0] route_flat
);
  for (genvar i = 0; i < NPE; i++) begin : g_hop
    localparam int SRC = (i + NPE - 1) % NPE;
    assign route_flat[i*DW +: DW] = acc_flat[SRC*DW +: DW];
  end
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int NPE    = 4,
  parameter int DW     = 8,
  parameter int LDEPTH = 16,
  parameter int PDEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_valid,
  output logic                      host_ready,
  input  logic                      host_to_prog,
  input  logic [$clog2(NPE)-1:0]    host_pe,
  input  logic [$clog2(PDEPTH)-1:0] host_addr,
  input  logic [DW-1:0]             host_data,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  input  logic [$clog2(NPE)-1:0]    rd_pe,
  input  logic [$clog2(LDEPTH)-1:0] rd_addr,
  output logic [DW-1:0]             rd_data
);
  localparam int LAW = $clog2(LDEPTH);

  logic              host_fire;
  logic              op_valid;
  op_e               op;
  logic [OPRW-1:0]   operand;
  logic [NPE-1:0]    mask;
  logic              clr_acc;
  logic [NPE*DW-1:0] acc_flat;
  logic [NPE*DW-1:0] route_flat;
  logic [DW-1:0]     rdata [NPE];

  assign host_ready = !busy;
  assign host_fire  = host_valid && host_ready;
  assign rd_data    = rdata[rd_pe];

  simd_ctrl #(.NPE(NPE), .PDEPTH(PDEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .prog_we    (host_fire && host_to_prog),
    .prog_waddr (host_addr),
    .prog_wdata (host_data[IW-1:0]),
    .busy       (busy),
    .done       (done),
    .op_valid   (op_valid),
    .op         (op),
    .operand    (operand),
    .mask       (mask),
    .clr_acc    (clr_acc)
  );

  simd_ring_net #(.NPE(NPE), .DW(DW)) u_net (
    .acc_flat   (acc_flat),
    .route_flat (route_flat)
  );

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    simd_pe #(.DW(DW), .LDEPTH(LDEPTH)) u_pe (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_acc),
      .op_valid   (op_valid),
      .en         (mask[i]),
      .op         (op),
      .addr       (operand[LAW-1:0]),
      .route_in   (route_flat[i*DW +: DW]),
      .host_we    (host_fire && !host_to_prog && (host_pe == i)),
      .host_waddr (host_addr[LAW-1:0]),
      .host_wdata (host_data),
      .host_raddr (rd_addr),
      .acc        (acc_flat[i*DW +: DW]),
      .host_rdata (rdata[i])
    );
  end
endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk #(
  parameter int NPE = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              host_ready,
  input logic              op_valid,
  input logic [2:0]        op,
  input logic [NPE-1:0]    mask,
  input logic [NPE*DW-1:0] acc_flat
);
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_ready); // R2

  AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  for (genvar i = 0; i < NPE; i++) begin : g_pe_chk
    localparam int SRC = (i + NPE - 1) % NPE;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !mask[i]) |=> (acc_flat[i*DW +: DW] == $past(acc_flat[i*DW +: DW]))); // R6

    AST_ROUTE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == 3'd6 && mask[i]) |=> (acc_flat[i*DW +: DW] == $past(acc_flat[SRC*DW +: DW]))); // R7
  end
endmodule

bind simd_pe_array simd_pe_array_chk #(.NPE(NPE), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .host_ready (host_ready),
  .op_valid   (op_valid),
  .op         (op),
  .mask       (mask),
  .acc_flat   (acc_flat)
);

// File: tb/simd_pe_array_bench.sv
module simd_pe_array_bench;
  localparam logic [2:0] I_LOAD = 3'd0, I_STORE = 3'd1, I_ADD = 3'd2, I_SUB = 3'd3,
                         I_AND = 3'd4, I_SETM = 3'd5, I_ROUTE = 3'd6, I_HALT = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic       host_to_prog = 1'b0;
  logic [1:0] host_pe = '0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic       start = 1'b0;
  logic       busy;
  logic       done;
  logic [1:0] rd_pe = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  simd_pe_array u_simd_pe_array (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_to_prog(host_to_prog), .host_pe(host_pe), .host_addr(host_addr),
    .host_data(host_data), .start(start), .busy(busy), .done(done),
    .rd_pe(rd_pe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] ins(logic [2:0] o, logic [4:0] a);
    return {o, a};
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(logic to_prog, int pe, int addr, int data);
    @(negedge clk);
    host_valid = 1'b1; host_to_prog = to_prog;
    host_pe = 2'(pe); host_addr = 5'(addr); host_data = 8'(data);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic check_mem(string req, int pe, int addr, int exp);
    @(negedge clk);
    rd_pe = 2'(pe); rd_addr = 4'(addr);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic run_prog(string req, int n_ins);
    int cyc = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 done cleared on start", int'(done), 0);
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check(req, cyc, 2 * n_ins);
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 host_ready", int'(host_ready), 1);
    check_mem("R1 store zero", 2, 5, 0);
  endtask

  task automatic t_arith;
    for (int i = 0; i < 4; i++) begin
      host_write(1'b0, i, 0, 10 + i);
      host_write(1'b0, i, 1, 20 * i + 5);
      host_write(1'b0, i, 2, 8'h0F);
    end
    host_write(1'b1, 0, 0, ins(I_LOAD, 0));
    host_write(1'b1, 0, 1, ins(I_ADD, 1));
    host_write(1'b1, 0, 2, ins(I_STORE, 3));
    host_write(1'b1, 0, 3, ins(I_LOAD, 0));
    host_write(1'b1, 0, 4, ins(I_SUB, 1));
    host_write(1'b1, 0, 5, ins(I_STORE, 4));
    host_write(1'b1, 0, 6, ins(I_LOAD, 1));
    host_write(1'b1, 0, 7, ins(I_AND, 2));
    host_write(1'b1, 0, 8, ins(I_STORE, 5));
    host_write(1'b1, 0, 9, ins(I_HALT, 0));
    check_mem("R11 readout", 3, 1, 65);
    run_prog("R8 ten instructions", 10);
    check("R10 idle after halt", int'(busy), 0);
    for (int i = 0; i < 4; i++) begin
      check_mem("R4 R5 add", i, 3, (10 + i + 20 * i + 5) % 256);
      check_mem("R4 R5 sub", i, 4, (10 + i - (20 * i + 5) + 256) % 256);
      check_mem("R4 R5 and", i, 5, (20 * i + 5) & 8'h0F);
    end
  endtask

  task automatic t_mask;
    for (int i = 0; i < 4; i++) begin
      host_write(1'b0, i, 6, 8'h40 + i);
      host_write(1'b0, i, 7, 8'hEE);
    end
    host_write(1'b1, 0, 0, ins(I_SETM, 5'b00101));
    host_write(1'b1, 0, 1, ins(I_LOAD, 6));
    host_write(1'b1, 0, 2, ins(I_STORE, 7));
    host_write(1'b1, 0, 3, ins(I_SETM, 5'b01111));
    host_write(1'b1, 0, 4, ins(I_STORE, 8));
    host_write(1'b1, 0, 5, ins(I_HALT, 0));
    run_prog("R8 six instructions", 6);
    for (int i = 0; i < 4; i++) begin
      check_mem("R6 masked store", i, 7, (i % 2 == 0) ? 8'h40 + i : 8'hEE);
      check_mem("R6 acc held", i, 8, (i % 2 == 0) ? 8'h40 + i : 0);
    end
  endtask

  task automatic t_route;
    host_write(1'b1, 0, 0, ins(I_LOAD, 0));
    host_write(1'b1, 0, 1, ins(I_SETM, 5'b01011));
    host_write(1'b1, 0, 2, ins(I_ROUTE, 0));
    host_write(1'b1, 0, 3, ins(I_SETM, 5'b01111));
    host_write(1'b1, 0, 4, ins(I_STORE, 9));
    host_write(1'b1, 0, 5, ins(I_HALT, 0));
    run_prog("R8 route program", 6);
    check_mem("R7 pe0 from pe3", 0, 9, 13);
    check_mem("R7 pe1 from pe0", 1, 9, 10);
    check_mem("R7 pe2 disabled", 2, 9, 12);
    check_mem("R7 pe3 from disabled pe2", 3, 9, 12);
  endtask

  task automatic t_busy_ignore;
    int cyc = 0;
    host_write(1'b1, 0, 0, ins(I_LOAD, 0));
    host_write(1'b1, 0, 1, ins(I_STORE, 10));
    for (int k = 2; k < 8; k++) host_write(1'b1, 0, k, ins(I_SETM, 5'b01111));
    host_write(1'b1, 0, 8, ins(I_HALT, 0));
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 1000) begin
      if (cyc == 4) begin
        check("R2 ready low while busy", int'(host_ready), 0);
        start = 1'b1; host_valid = 1'b1; host_to_prog = 1'b0;
        host_pe = 2'd0; host_addr = 5'd0; host_data = 8'h99;
      end else begin
        start = 1'b0; host_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; host_valid = 1'b0;
    check("R9 start ignored while busy", cyc, 18);
    check_mem("R2 write dropped while busy", 0, 0, 10);
    for (int i = 0; i < 4; i++) check_mem("R3 own store operand", i, 10, 10 + i);
    check("R10 done held", int'(done), 1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_mask();
    t_route();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule